// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block turns 32 general-purpose input lines into four grouped interrupt requests for a main interrupt controller. Each line is brought into the clock domain by a two-flop synchroniser. It is then optionally inverted by a per-line polarity bit, and the result is called data-in. Two sensing paths act on data-in. The level path passes data-in through a level mask. The edge path records every low-to-high change of data-in in a sticky edge cause register, which is then gated by an edge mask.

A line counts only when its direction bit marks it as an input. The two masked paths are ORed per line. Each group of eight consecutive lines is then ORed into one summary request. Software reaches the registers through a simple word-addressed read/write port. It can catch both edges of a signal by flipping the polarity bit of a line after each capture. A polarity flip on a steady line is seen as a change of data-in, so it is itself captured.

Top module: `gpio_irq_agg`

## Requirements
- R1: data-in bit i equals the synchronised line i when polarity bit i is 0, and its inverse when polarity bit i is 1. A line change shows in data-in, and in any level request, after two rising clock edges.
- R2: A line whose level mask bit is 1 contributes its data-in value to the cause.
- R3: A 0-to-1 change of data-in on an input line sets the matching edge cause bit one edge after data-in changes. With polarity 0 this captures rising line edges, and with polarity 1 it captures falling line edges.
- R4: Edge cause bits are sticky. A write to the edge cause register clears each bit whose write data is 0 and leaves each bit whose write data is 1 unchanged.
- R5: When a new edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: The cause of line i is (data-in AND level mask) OR (edge cause AND edge mask), ANDed with direction bit i.
- R7: irq_grp[g] is the OR of cause bits 8g to 8g+7, for g = 0 to 3.
- R8: A line whose direction bit is 0 (output) neither sets an edge cause bit nor contributes to any request.
- R9: Flipping a polarity bit while its line is steady changes data-in. If data-in goes 0 to 1, this is captured as an edge.
- R10: After reset the polarity, direction, level mask, edge mask and edge cause registers are all zero, and irq_grp is zero.
- R11: Word addresses are 0 data-in (read only; writes ignored), 1 polarity, 2 direction, 3 edge cause, 4 edge mask and 5 level mask. Addresses 6 and 7 read as zero. Read data appears on the clock edge that samples reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | 32 | Raw asynchronous GPIO lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_grp | output | 4 | Per-group summary interrupt requests |

## Verification
A line change driven between edges reaches data-in and any level request after two rising edges. The bench checks for absence after one edge and for presence after two. An edge capture takes three rising edges from the line change, so the bench checks that it is absent after two and present after three. Register writes take effect on the edge that samples them, and read data is sampled one edge after the read strobe. A polarity write can produce an edge one edge later, so every write is followed by two idle cycles before the bench model counts the write as settled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIN    = 3'd0,
    SEL_POL    = 3'd1,
    SEL_DIR    = 3'd2,
    SEL_ECAUSE = 3'd3,
    SEL_EMASK  = 3'd4,
    SEL_LMASK  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] qual,
  input  logic         clr_en,
  input  logic [W-1:0] keep,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] hit
);
  logic [W-1:0] din_q;

  function automatic logic [W-1:0] rise_of(input logic [W-1:0] prev,
                                            input logic [W-1:0] cur);
    return cur & ~prev;
  endfunction

  assign hit = rise_of(din_q, din) & qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q   <= '0;
      cause_q <= '0;
    end else begin
      din_q <= din;
      if (clr_en) cause_q <= (cause_q & keep) | hit;
      else        cause_q <= cause_q | hit;
    end
  end
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
  parameter int W = 32,
  parameter int G = 8,
  localparam int NG = W / G
) (
  input  logic [W-1:0]  vec,
  output logic [NG-1:0] grp
);
  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp[g] = |vec[g*G +: G];
  end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 32,
  parameter int GROUP = 8,
  localparam int NGRP = LINES / GROUP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  gpio_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LINES-1:0]  reg_wdata,
  output logic [LINES-1:0]  reg_rdata,
  output logic [NGRP-1:0]   irq_grp
);
  logic [LINES-1:0] sync_q;
  logic [LINES-1:0] data_in;
  logic [LINES-1:0] pol_q, dir_q, lmask_q, emask_q;
  logic [LINES-1:0] ecause_q;
  logic [LINES-1:0] edge_hit;
  logic [LINES-1:0] cause_vec;
  logic             ecause_wr;

  function automatic logic [LINES-1:0] combine_cause(
    input logic [LINES-1:0] din, input logic [LINES-1:0] lm,
    input logic [LINES-1:0] ec,  input logic [LINES-1:0] em,
    input logic [LINES-1:0] dir);
    return ((din & lm) | (ec & em)) & dir;
  endfunction

  gpio_sync #(.W(LINES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(sync_q)
  );

  assign data_in   = sync_q ^ pol_q;
  assign ecause_wr = reg_wr && (reg_addr == SEL_ECAUSE);

  gpio_edge_cause #(.W(LINES)) edge_i (
    .clk(clk), .rst_n(rst_n), .din(data_in), .qual(dir_q),
    .clr_en(ecause_wr), .keep(reg_wdata),
    .cause_q(ecause_q), .hit(edge_hit)
  );

  assign cause_vec = combine_cause(data_in, lmask_q, ecause_q, emask_q, dir_q);

  gpio_group_or #(.W(LINES), .G(GROUP)) grp_i (
    .vec(cause_vec), .grp(irq_grp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= '0;
      dir_q   <= '0;
      lmask_q <= '0;
      emask_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        SEL_POL:   pol_q   <= reg_wdata;
        SEL_DIR:   dir_q   <= reg_wdata;
        SEL_EMASK: emask_q <= reg_wdata;
        SEL_LMASK: lmask_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        SEL_DIN:    reg_rdata <= data_in;
        SEL_POL:    reg_rdata <= pol_q;
        SEL_DIR:    reg_rdata <= dir_q;
        SEL_ECAUSE: reg_rdata <= ecause_q;
        SEL_EMASK:  reg_rdata <= emask_q;
        SEL_LMASK:  reg_rdata <= lmask_q;
        default:    reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 32,
  parameter int NGRP  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [LINES-1:0]  reg_wdata,
  input logic [LINES-1:0]  reg_rdata,
  input logic [NGRP-1:0]   irq_grp,
  input logic [LINES-1:0]  pol_q,
  input logic [LINES-1:0]  dir_q,
  input logic [LINES-1:0]  lmask_q,
  input logic [LINES-1:0]  emask_q,
  input logic [LINES-1:0]  ecause_q,
  input logic [LINES-1:0]  edge_hit
);
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((ecause_q & $past(edge_hit)) == $past(edge_hit))); // R5

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == SEL_ECAUSE) |=> (($past(ecause_q) & ~ecause_q) == '0)); // R4

  AST_CLEAR_ZEROS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SEL_ECAUSE) |=>
      ((($past(ecause_q) & $past(reg_wdata)) & ~ecause_q) == '0)); // R4

  AST_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == '0) |-> (irq_grp == '0)); // R8

  AST_MASKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (lmask_q == '0 && emask_q == '0) |-> (irq_grp == '0)); // R6

  AST_READ_POL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == SEL_POL) |=> (reg_rdata == $past(pol_q))); // R11
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.LINES(LINES), .NGRP(NGRP)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_grp(irq_grp), .pol_q(pol_q), .dir_q(dir_q), .lmask_q(lmask_q),
  .emask_q(emask_q), .ecause_q(ecause_q), .edge_hit(edge_hit)
);

// File: tb/gpio_irq_agg_tb.sv
`timescale 1ns/1ps
module gpio_irq_agg_tb_top;
  localparam int L = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [L-1:0]  gpio_in = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [L-1:0]  reg_wdata = '0;
  logic [L-1:0]  reg_rdata;
  logic [3:0]    irq_grp;

  int total = 0, bad = 0;

  // bench model, kept from the requirements
  logic [L-1:0] m_line = '0, m_pol = '0, m_dir = '0, m_lm = '0, m_em = '0, m_ec = '0;

  always #10 clk = ~clk;

  gpio_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_grp(irq_grp)
  );

  function automatic logic [L-1:0] exp_din();
    return m_line ^ m_pol;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [L-1:0] c;
    logic [3:0] r;
    c = ((exp_din() & m_lm) | (m_ec & m_em)) & m_dir;
    for (int g = 0; g < 4; g++) r[g] = (c[8*g +: 8] != 8'h0);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [L-1:0] got, input logic [L-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [L-1:0] d);
    logic [L-1:0] old_din;
    old_din = exp_din();
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      3'd1: begin m_pol = d; m_ec |= (exp_din() & ~old_din) & m_dir; end
      3'd2: m_dir = d;
      3'd3: m_ec &= d;
      3'd4: m_em = d;
      3'd5: m_lm = d;
      default: ;
    endcase
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [L-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_line(input logic [L-1:0] v);
    logic [L-1:0] old_din;
    old_din = exp_din();
    @(negedge clk);
    gpio_in = v; m_line = v;
    m_ec |= (exp_din() & ~old_din) & m_dir;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [L-1:0] d;
    chk({tag, " irq"}, {28'h0, irq_grp}, {28'h0, exp_irq()});
    rd(3'd3, d); chk({tag, " ecause"}, d, m_ec);
    rd(3'd0, d); chk({tag, " din"}, d, exp_din());
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [L-1:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 irq", {28'h0, irq_grp}, '0);
    for (int a = 1; a < 6; a++) begin
      rd(a[2:0], d); chk("R10 reg", d, '0);
    end
    // R11 unmapped, read-only data-in
    rd(3'd7, d); chk("R11 unmapped", d, '0);
    wr(3'd0, '1);
    rd(3'd0, d); chk("R11 din ro", d, exp_din());

    // R1 R2 R7 level timing
    wr(3'd2, '1);
    wr(3'd5, 32'h0000_0100);
    @(negedge clk); gpio_in[8] = 1'b1; m_line[8] = 1'b1;
    m_ec[8] = 1'b1;
    @(negedge clk); chk("R1 level after 1 edge", {28'h0, irq_grp}, '0);
    @(negedge clk); chk("R2 R7 level after 2 edges", {28'h0, irq_grp}, 32'h2);
    rd(3'd0, d); chk("R1 din", d, exp_din());
    set_line('0); wr(3'd5, '0); wr(3'd3, '0);

    // R3 rising edge timing, R4 sticky and write semantics
    wr(3'd4, 32'h0010_0000);
    @(negedge clk); gpio_in[20] = 1'b1; m_line[20] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3 edge after 2 edges", {28'h0, irq_grp}, '0);
    @(negedge clk);
    chk("R3 edge after 3 edges", {28'h0, irq_grp}, 32'h4);
    m_ec[20] = 1'b1;
    set_line('0);
    check_all("R4 sticky");
    wr(3'd3, '1);   check_all("R4 write one keeps");
    wr(3'd3, ~32'h0010_0000); check_all("R4 write zero clears");

    // R9 polarity flip on steady low line, R3 falling capture
    wr(3'd1, 32'h0010_0000); check_all("R9 pol flip");
    wr(3'd3, '0);
    set_line(32'h0010_0000); check_all("R3 pol1 rise ignored");
    set_line('0);            check_all("R3 pol1 fall caught");
    wr(3'd3, '0); wr(3'd1, '0);

    // R8 output lines
    wr(3'd2, ~32'h0000_0020); wr(3'd4, 32'h20); wr(3'd5, 32'h20);
    set_line(32'h20); check_all("R8 out line quiet");
    set_line('0);
    wr(3'd2, '1); wr(3'd5, '0);

    // R5 edge and clear in the same cycle
    @(negedge clk); gpio_in[3] = 1'b1; m_line[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = '0;
    @(negedge clk); reg_wr = 1'b0;
    m_ec = 32'h8;
    check_all("R5 edge beats clear");
    set_line('0); wr(3'd3, '0);

    // R6 randomized mix
    for (int it = 0; it < 60; it++) begin
      wr(3'd2, $urandom());
      wr(3'd5, $urandom());
      wr(3'd4, $urandom());
      wr(3'd1, $urandom());
      set_line($urandom());
      if ($urandom_range(0, 1) == 1) wr(3'd3, $urandom());
      check_all("R6 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule